// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands of `W` bits (8 by default) with a single full adder, reusing it over `W` clock cycles. An operand pair comes in through a valid/ready handshake and is loaded in parallel into two shift registers. A new operation also clears the stored carry. On each enabled clock, both operand registers move one place toward bit 0. The full adder combines their bit-0 outputs with the stored carry. The sum bit enters the result register at its top end, and the carry-out is captured in a flip-flop for the next cycle. After `W` enabled shifts, the first sum bit has reached bit 0 of the result.

The result and the final carry (the unsigned overflow) are offered on an output valid/ready handshake. The rules for back-pressure are as follows. `in_ready` is high only while the block is idle, so an operand pair is accepted only on a clock where both `in_valid` and `in_ready` are high. Once `out_valid` is high, the result and the carry stay frozen until a clock where `out_ready` is high. After that clock the block returns to idle. The plain input `step_en` gates progress: on a clock where it is low, no register moves.

Top module: `bitser_adder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and `out_sum` and `out_carry` are 0.
- R2: When `out_valid` is 1, `out_sum` equals (`in_a` + `in_b`) mod 2^W for the accepted pair, and `out_carry` equals bit W of the full sum.
- R3: With `step_en` held at 1, `out_valid` becomes 1 exactly W clock edges after the edge that accepts the operands.
- R4: A clock edge during computation with `step_en` at 0 makes no progress. `out_valid` rises only after W edges with `step_en` at 1, and the result is unaffected by stalls.
- R5: `in_ready` is 0 from the accepting edge until the result is released. `in_valid` and the operand inputs are ignored during that time.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sum` and `out_carry` hold their values.
- R7: On the edge where `out_valid` and `out_ready` are both 1, the block releases the result: after that edge `out_valid` is 0 and `in_ready` is 1.
- R8: Accepting a new pair clears the stored carry, so a carry-out left over from the previous operation never enters the next sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block is idle and will take a pair |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| step_en | input | 1 | Enables one shift/add step on this clock |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | W | Sum modulo 2^W |
| out_carry | output | 1 | Final carry (unsigned overflow) |

## Verification
A stuck or stale carry flip-flop shows up as a wrong `out_sum` or `out_carry` as soon as the first result is offered. Such a fault is easiest to expose with operand pairs whose carries propagate across every bit, such as all-ones plus one. It also shows when an operation that produces a carry-out is followed by one that produces none. A fault in the step counter or in the `step_en` gating changes the number of edges before `out_valid` rises, so it is caught W edges after acceptance. A wrong shift direction scrambles the bit order of `out_sum` in the first result.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bsa_state_e;
endpackage

// File: rtl/bsa_shreg.sv
// Parallel-load register that shifts toward bit 0, filling from the top.
module bsa_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= ld_val;
    else if (shift)  q <= {sin, q[W-1:1]};
  end
endmodule

// File: rtl/bsa_fa_carry.sv
// One full adder with its carry flip-flop.
module bsa_fa_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic sum,
  output logic carry_q
);
  logic cout;

  assign sum  = a ^ b ^ carry_q;
  assign cout = (a & b) | (carry_q & (a ^ b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   carry_q <= 1'b0;
    else if (clr) carry_q <= 1'b0;
    else if (en)  carry_q <= cout;
  end
endmodule

// File: rtl/bsa_seq.sv
// Handshake and step sequencing.
module bsa_seq
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic step_en,
  output logic load,
  output logic shift,
  output logic in_ready,
  output logic out_valid
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  bsa_state_e    state;
  logic [CW-1:0] cnt;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign load      = in_ready && in_valid;
  assign shift     = (state == ST_RUN) && step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: if (shift) begin
          if (cnt == LAST) state <= ST_DONE;
          cnt <= cnt + 1'b1;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         step_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_sum,
  output logic         out_carry
);
  localparam int NOPS = 2;

  logic         load, shift, sum_bit, carry_q;
  logic [W-1:0] op_ld [NOPS];
  logic [W-1:0] op_q  [NOPS];
  logic [W-1:0] z_q;

  assign op_ld[0] = in_a;
  assign op_ld[1] = in_b;

  bsa_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .step_en(step_en), .load(load), .shift(shift),
    .in_ready(in_ready), .out_valid(out_valid)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    bsa_shreg #(.W(W)) u_op (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_val(op_ld[g]),
      .shift(shift), .sin(1'b0), .q(op_q[g])
    );
  end

  bsa_fa_carry u_fa (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(shift),
    .a(op_q[0][0]), .b(op_q[1][0]), .sum(sum_bit), .carry_q(carry_q)
  );

  bsa_shreg #(.W(W)) u_z (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val('0),
    .shift(shift), .sin(sum_bit), .q(z_q)
  );

  assign out_sum   = z_q;
  assign out_carry = carry_q;
endmodule

// File: rtl/bsa_chk.sv
module bsa_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         step_en,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_sum,
  input logic         out_carry
);
  logic [31:0] steps;
  logic        busy;

  assign busy = !in_ready && !out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     steps <= '0;
    else if (in_valid && in_ready)  steps <= '0;
    else if (busy && step_en)       steps <= steps + 1;
  end

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid); // R5
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> steps == W); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step_en |=> !out_valid); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_carry)); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready); // R7
endmodule

bind bitser_adder bsa_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .step_en(step_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_sum(out_sum), .out_carry(out_carry)
);

// File: tb/sim_bitser_adder.sv
module sim_bitser_adder;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, step_en = 1'b1, out_ready = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         in_ready, out_valid, out_carry;
  logic [W-1:0] out_sum;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  bitser_adder #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .step_en(step_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_carry(out_carry)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic check(bit ok, string req, longint got, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WDOG);
        summary();
      end
    end
  end

  // Offer a pair, run with a stall pattern, check result; optional extras.
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit rnd_stall,
                        bit poke_busy, int hold_cycles, bit chk_lat);
    logic [W:0] exp = ref_sum(a, b);
    int n = 0;
    int en_cnt = 0;
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    check(in_ready == 1'b1, "R5 idle ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) begin
      if (poke_busy) begin
        in_valid = 1'b1; in_a = ~a; in_b = b + 8'd3;
      end
      step_en = rnd_stall ? 1'($urandom_range(0, 1)) : 1'b1;
      if (step_en) en_cnt++;
      n++;
      @(negedge clk);
      if (poke_busy && !out_valid) check(in_ready == 1'b0, "R5 busy not ready", in_ready, 0);
      if (n > 10 * W + 100) break;
    end
    in_valid = 1'b0;
    step_en = 1'b1;
    if (chk_lat) check(n == W, "R3 latency", n, W);
    if (rnd_stall) check(en_cnt == W, "R4 enabled steps", en_cnt, W);
    check(out_sum == exp[W-1:0], "R2 sum", out_sum, exp[W-1:0]);
    check(out_carry == exp[W], "R2 carry", out_carry, exp[W]);
    for (int i = 0; i < hold_cycles; i++) begin
      @(negedge clk);
      check(out_valid && out_sum == exp[W-1:0] && out_carry == exp[W],
            "R6 hold", {out_valid, out_carry, out_sum}, {1'b1, exp});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R7 release", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 handshake reset",
          {in_ready, out_valid}, 2'b10);
    check(out_sum == '0 && out_carry == 1'b0, "R1 data reset",
          {out_carry, out_sum}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(8'hFF, 8'h01, 0, 0, 0, 1);   // R2 full carry chain
    run_op(8'h00, 8'h00, 0, 0, 0, 1);   // R8 no stale carry
    run_op(8'hFF, 8'hFF, 0, 0, 2, 1);   // R6 hold with carry
    run_op(8'h01, 8'h00, 0, 0, 0, 1);   // R8 carry cleared again
    run_op(8'hA5, 8'h5A, 1, 0, 0, 0);   // R4 stalls
    run_op(8'h80, 8'h80, 0, 1, 3, 1);   // R5 busy pokes ignored
    for (int k = 0; k < 40; k++) begin
      run_op(W'($urandom), W'($urandom), bit'(k % 3 == 0), bit'(k % 5 == 0),
             k % 4, bit'(k % 3 != 0));
    end
    summary();
  end
endmodule